// File: doc/BRIEF.md
# DS3 Frame Parity Generator and Checker

This block sits on a serial DS3 bit stream behind a framer. The framer reports a frame-start strobe and a lock indication. The block keeps its own bit position inside the M-frame. It folds every payload bit into an even-parity accumulator. When a frame ends, it keeps that parity for use in the next frame. On the receive side it compares the two P-bits, and in C-bit parity mode the three CP-bits, against the parity of the previous frame. It reports disagreement with one-cycle strobes.

On the transmit side the same stream is forwarded with one cycle of latency. The P-bit slots are always rewritten with the locally computed parity, so each hop regenerates them. CP-bit slots are rewritten only when the node is a path terminal. In mid-network mode the CP-bits are forwarded untouched, so path parity stays end-to-end. No comparison is made until one complete, locked frame has been accumulated. This holds after reset and after any loss of lock.

Top module: `ds3_parity_gc`

## Requirements
- R1: A frame is SUBFRAMES × BLOCKS blocks. Each block is one overhead bit followed by PAY_BITS payload bits, with subframes and blocks numbered from 0. `frame_start` marks the first overhead bit (subframe 0, block 0). Position advances only on cycles with `bit_valid` high.
- R2: Parity is even parity over all payload bits of one frame. The parity of frame N is written onto `tx_bit` in both P-bit slots of frame N+1: the overhead bit of block 0 in subframes 2 and 3. Every other non-CP bit is forwarded unchanged, one cycle after it is accepted.
- R3: `p_err` pulses for one cycle, in the output cycle of the second P-bit, when either received P-bit differs from the parity of the previous frame's received payload.
- R4: `p_mismatch` pulses in the output cycle of the second P-bit when the two received P-bits differ from each other, while the framer is locked.
- R5: In C-bit mode (`cbit_mode`=1), the CP-bits are the overhead bits of blocks 2, 4 and 6 in subframe 2. `cp_err` pulses in the output cycle of the third one when any of the three differs from the previous frame's parity.
- R6: In C-bit mode with `mid_net`=0, the CP slots carry the computed parity on `tx_bit`. With `mid_net`=1 they carry the received bits unchanged.
- R7: With `cbit_mode`=0, the CP slots are forwarded unchanged and `cp_err` never pulses.
- R8: No P or CP comparison is made in a frame unless the previous frame and the current frame both started with `in_frame` high. In such a frame the P and CP slots are filled with 0 where insertion applies.
- R9: While `rst` is high, all outputs are 0.
- R10: A cycle with `bit_valid` low gives `tx_valid`=0 and `tx_bit`=0 in the next cycle, raises no strobe, and does not advance the position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_valid | input | 1 | `rx_bit` holds a stream bit this cycle |
| frame_start | input | 1 | Current bit is the first bit of an M-frame |
| in_frame | input | 1 | Framer is locked |
| rx_bit | input | 1 | Received serial bit |
| cbit_mode | input | 1 | 1 = C-bit parity format, 0 = plain format |
| mid_net | input | 1 | 1 = mid-network node, 0 = path terminal |
| tx_bit | output | 1 | Forwarded bit with parity slots rewritten |
| tx_valid | output | 1 | `tx_bit` is valid |
| p_err | output | 1 | P-bit parity error strobe |
| p_mismatch | output | 1 | The two P-bits disagree |
| cp_err | output | 1 | CP-bit parity error strobe |

## Verification
Every output is registered once. The result for an accepted bit is therefore due in the cycle after its accepting edge. `p_err` and `p_mismatch` belong to the second P-bit, and `cp_err` belongs to the third CP-bit. The bench samples one nanosecond after each edge and tags every sample with the frame index of the bit that produced it. Each strobe must appear exactly once, at the index of that slot bit, and nowhere else in the frame. A payload error injected in frame N is therefore accepted only if its `p_err` lands on the second P-bit of frame N+1.

// File: rtl/ds3_par_pkg.sv
package ds3_par_pkg;
  // Kind of bit at the current frame position
  typedef enum logic [2:0] {
    SL_PAY,
    SL_OH,
    SL_P1,
    SL_P2,
    SL_C1,
    SL_C2,
    SL_C3
  } slot_t;

  // Slot locations (subframe, block) within the M-frame
  localparam int P1_SUB = 2;
  localparam int P2_SUB = 3;
  localparam int C_SUB  = 2;
  localparam int C1_BLK = 2;
  localparam int C2_BLK = 4;
  localparam int C3_BLK = 6;
endpackage

// File: rtl/ds3_frame_pos.sv
module ds3_frame_pos
  import ds3_par_pkg::*;
#(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int PAY_BITS  = 84
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_valid,
  input  logic  frame_start,
  output slot_t slot
);
  localparam int SW = $clog2(SUBFRAMES);
  localparam int BW = $clog2(BLOCKS);
  localparam int KW = $clog2(PAY_BITS + 1);
  localparam logic [SW-1:0] SUB_LAST = SW'(SUBFRAMES - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(BLOCKS - 1);
  localparam logic [KW-1:0] K_LAST   = KW'(PAY_BITS);

  logic [SW-1:0] sub_q, sub_c;
  logic [BW-1:0] blk_q, blk_c;
  logic [KW-1:0] k_q,   k_c;

  // Position of the bit on the input this cycle
  always_comb begin
    sub_c = frame_start ? '0 : sub_q;
    blk_c = frame_start ? '0 : blk_q;
    k_c   = frame_start ? '0 : k_q;
  end

  always_comb begin
    if (k_c != '0)                                          slot = SL_PAY;
    else if (blk_c == '0 && sub_c == SW'(P1_SUB))           slot = SL_P1;
    else if (blk_c == '0 && sub_c == SW'(P2_SUB))           slot = SL_P2;
    else if (sub_c == SW'(C_SUB) && blk_c == BW'(C1_BLK))   slot = SL_C1;
    else if (sub_c == SW'(C_SUB) && blk_c == BW'(C2_BLK))   slot = SL_C2;
    else if (sub_c == SW'(C_SUB) && blk_c == BW'(C3_BLK))   slot = SL_C3;
    else                                                    slot = SL_OH;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      blk_q <= '0;
      k_q   <= '0;
    end else if (bit_valid) begin
      if (k_c == K_LAST) begin
        k_q <= '0;
        if (blk_c == BLK_LAST) begin
          blk_q <= '0;
          sub_q <= (sub_c == SUB_LAST) ? '0 : sub_c + 1'b1;
        end else begin
          blk_q <= blk_c + 1'b1;
          sub_q <= sub_c;
        end
      end else begin
        k_q   <= k_c + 1'b1;
        blk_q <= blk_c;
        sub_q <= sub_c;
      end
    end
  end
endmodule

// File: rtl/ds3_par_acc.sv
module ds3_par_acc (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic frame_start,
  input  logic in_frame,
  input  logic is_pay,
  input  logic data,
  output logic held_par,
  output logic held_valid,
  output logic acc_valid
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (rst || !in_frame) begin
      acc_q      <= 1'b0;
      acc_valid  <= 1'b0;
      held_par   <= 1'b0;
      held_valid <= 1'b0;
    end else if (bit_valid) begin
      if (frame_start) begin
        // Close the finished frame; keep its parity only if it was locked from its start
        held_par   <= acc_valid & acc_q;
        held_valid <= acc_valid;
        acc_valid  <= 1'b1;
        acc_q      <= is_pay & data;
      end else if (is_pay) begin
        acc_q <= acc_q ^ data;
      end
    end
  end
endmodule

// File: rtl/ds3_par_check.sv
module ds3_par_check
  import ds3_par_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  bit_valid,
  input  slot_t slot,
  input  logic  data,
  input  logic  in_frame,
  input  logic  cbit_mode,
  input  logic  held_par,
  input  logic  held_valid,
  input  logic  acc_valid,
  output logic  p_err,
  output logic  p_mismatch,
  output logic  cp_err
);
  logic p1_q, c1_q, c2_q;
  logic chk_en;

  assign chk_en = in_frame & held_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1_q       <= 1'b0;
      c1_q       <= 1'b0;
      c2_q       <= 1'b0;
      p_err      <= 1'b0;
      p_mismatch <= 1'b0;
      cp_err     <= 1'b0;
    end else begin
      p_err      <= 1'b0;
      p_mismatch <= 1'b0;
      cp_err     <= 1'b0;
      if (bit_valid) begin
        unique case (slot)
          SL_P1: p1_q <= data;
          SL_C1: c1_q <= data;
          SL_C2: c2_q <= data;
          SL_P2: begin
            p_err      <= chk_en & ((p1_q != held_par) | (data != held_par));
            p_mismatch <= in_frame & acc_valid & (p1_q != data);
          end
          SL_C3: cp_err <= cbit_mode & chk_en &
                           ((c1_q != held_par) | (c2_q != held_par) | (data != held_par));
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ds3_parity_gc.sv
module ds3_parity_gc
  import ds3_par_pkg::*;
#(
  parameter int SUBFRAMES = 7,
  parameter int BLOCKS    = 8,
  parameter int PAY_BITS  = 84
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_valid,
  input  logic frame_start,
  input  logic in_frame,
  input  logic rx_bit,
  input  logic cbit_mode,
  input  logic mid_net,
  output logic tx_bit,
  output logic tx_valid,
  output logic p_err,
  output logic p_mismatch,
  output logic cp_err
);
  slot_t slot;
  logic  held_par, held_valid, acc_valid;
  logic  tx_next;

  ds3_frame_pos #(
    .SUBFRAMES(SUBFRAMES),
    .BLOCKS   (BLOCKS),
    .PAY_BITS (PAY_BITS)
  ) u_pos (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .frame_start(frame_start),
    .slot       (slot)
  );

  ds3_par_acc u_acc (
    .clk        (clk),
    .rst        (rst),
    .bit_valid  (bit_valid),
    .frame_start(frame_start),
    .in_frame   (in_frame),
    .is_pay     (slot == SL_PAY),
    .data       (rx_bit),
    .held_par   (held_par),
    .held_valid (held_valid),
    .acc_valid  (acc_valid)
  );

  ds3_par_check u_chk (
    .clk       (clk),
    .rst       (rst),
    .bit_valid (bit_valid),
    .slot      (slot),
    .data      (rx_bit),
    .in_frame  (in_frame),
    .cbit_mode (cbit_mode),
    .held_par  (held_par),
    .held_valid(held_valid),
    .acc_valid (acc_valid),
    .p_err     (p_err),
    .p_mismatch(p_mismatch),
    .cp_err    (cp_err)
  );

  // Slot rewrite: P always regenerated, CP only at a path terminal in C-bit mode
  always_comb begin
    unique case (slot)
      SL_P1, SL_P2:        tx_next = held_par;
      SL_C1, SL_C2, SL_C3: tx_next = (cbit_mode && !mid_net) ? held_par : rx_bit;
      default:             tx_next = rx_bit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_bit   <= 1'b0;
      tx_valid <= 1'b0;
    end else begin
      tx_bit   <= bit_valid & tx_next;
      tx_valid <= bit_valid;
    end
  end
endmodule

// File: rtl/ds3_par_sva.sv
module ds3_par_sva
  import ds3_par_pkg::*;
(
  input logic  clk,
  input logic  rst,
  input logic  bit_valid,
  input logic  in_frame,
  input logic  rx_bit,
  input logic  cbit_mode,
  input logic  mid_net,
  input slot_t slot,
  input logic  tx_bit,
  input logic  tx_valid,
  input logic  p_err,
  input logic  p_mismatch,
  input logic  cp_err
);
  AST_PERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    p_err |=> !p_err); // R3

  AST_PMIS_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
    p_mismatch |-> tx_valid); // R4

  AST_NO_CHECK_UNLOCKED: assert property (@(posedge clk) disable iff (rst)
    !$past(in_frame) |-> (!p_err && !cp_err)); // R8

  AST_CP_QUIET_PLAIN: assert property (@(posedge clk) disable iff (rst)
    !$past(cbit_mode) |-> !cp_err); // R7

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tx_valid == $past(bit_valid))); // R10

  AST_MID_CP_PASS: assert property (@(posedge clk) disable iff (rst)
    ($past(bit_valid) && $past(mid_net) &&
     ($past(slot) == SL_C1 || $past(slot) == SL_C2 || $past(slot) == SL_C3))
    |-> (tx_bit == $past(rx_bit))); // R6
endmodule

bind ds3_parity_gc ds3_par_sva u_sva (
  .clk       (clk),
  .rst       (rst),
  .bit_valid (bit_valid),
  .in_frame  (in_frame),
  .rx_bit    (rx_bit),
  .cbit_mode (cbit_mode),
  .mid_net   (mid_net),
  .slot      (slot),
  .tx_bit    (tx_bit),
  .tx_valid  (tx_valid),
  .p_err     (p_err),
  .p_mismatch(p_mismatch),
  .cp_err    (cp_err)
);

// File: tb/tb_ds3_parity_gc.sv
`timescale 1ns/1ps
module tb_ds3_parity_gc;
  localparam int SF   = 7;
  localparam int BL   = 8;
  localparam int PB   = 3;
  localparam int BLEN = PB + 1;
  localparam int FLEN = SF * BL * BLEN;
  localparam int IP1  = (2 * BL) * BLEN;
  localparam int IP2  = (3 * BL) * BLEN;
  localparam int IC1  = (2 * BL + 2) * BLEN;
  localparam int IC2  = (2 * BL + 4) * BLEN;
  localparam int IC3  = (2 * BL + 6) * BLEN;

  logic clk = 1'b0;
  logic rst, bit_valid, frame_start, in_frame, rx_bit, cbit_mode, mid_net;
  logic tx_bit, tx_valid, p_err, p_mismatch, cp_err;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic obs_tx, obs_v, obs_p, obs_m, obs_c;
  bit   exp_prev_par   = 1'b0;
  bit   exp_prev_valid = 1'b0;
  bit   claim_flip     = 1'b0;
  bit   gaps           = 1'b0;

  always #2.5 clk = ~clk;

  ds3_parity_gc #(.SUBFRAMES(SF), .BLOCKS(BL), .PAY_BITS(PB)) dut (
    .clk(clk), .rst(rst), .bit_valid(bit_valid), .frame_start(frame_start),
    .in_frame(in_frame), .rx_bit(rx_bit), .cbit_mode(cbit_mode), .mid_net(mid_net),
    .tx_bit(tx_bit), .tx_valid(tx_valid), .p_err(p_err), .p_mismatch(p_mismatch),
    .cp_err(cp_err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic drive(input logic v, input logic b, input logic fs);
    @(negedge clk);
    bit_valid   = v;
    rx_bit      = b;
    frame_start = fs;
    @(posedge clk);
    #1;
    obs_tx = tx_bit; obs_v = tx_valid; obs_p = p_err; obs_m = p_mismatch; obs_c = cp_err;
  endtask

  // err: 0 none, 1 flip P1, 2 flip P2, 3 flip both P, 4 payload hit, 5..7 flip C1..C3
  task automatic run_frame(input bit inf, input int err);
    bit bits [FLEN];
    bit par, claim, ins, exp_pe, exp_me, exp_ce, want;
    int np, nm, nc, ip, im, ic, bad_p, bad_c, bad_o, bad_idle;
    np = 0; nm = 0; nc = 0; ip = -1; im = -1; ic = -1;
    bad_p = 0; bad_c = 0; bad_o = 0; bad_idle = 0;
    in_frame = inf;
    claim = exp_prev_par ^ claim_flip;
    for (int i = 0; i < FLEN; i++) bits[i] = 1'($urandom);
    bits[IP1] = claim; bits[IP2] = claim;
    bits[IC1] = claim; bits[IC2] = claim; bits[IC3] = claim;
    if (err == 1 || err == 3) bits[IP1] = ~claim;
    if (err == 2 || err == 3) bits[IP2] = ~claim;
    if (err == 5) bits[IC1] = ~claim;
    if (err == 6) bits[IC2] = ~claim;
    if (err == 7) bits[IC3] = ~claim;
    par = 1'b0;
    for (int i = 0; i < FLEN; i++) if ((i % BLEN) != 0) par ^= bits[i];
    ins    = (inf && exp_prev_valid) ? exp_prev_par : 1'b0;
    exp_pe = inf && exp_prev_valid && (bits[IP1] != exp_prev_par || bits[IP2] != exp_prev_par);
    exp_me = inf && (bits[IP1] != bits[IP2]);
    exp_ce = cbit_mode && inf && exp_prev_valid &&
             (bits[IC1] != exp_prev_par || bits[IC2] != exp_prev_par || bits[IC3] != exp_prev_par);
    for (int i = 0; i < FLEN; i++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        drive(1'b0, 1'($urandom), 1'b0);
        if (obs_v || obs_tx || obs_p || obs_m || obs_c) bad_idle++;
      end
      drive(1'b1, bits[i], i == 0);
      if (i == IP1 || i == IP2) begin
        want = ins;
        if (obs_tx != want) bad_p++;
      end else if (i == IC1 || i == IC2 || i == IC3) begin
        want = (cbit_mode && !mid_net) ? ins : bits[i];
        if (obs_tx != want) bad_c++;
      end else if (obs_tx != bits[i] || !obs_v) bad_o++;
      if (obs_p) begin np++; ip = i; end
      if (obs_m) begin nm++; im = i; end
      if (obs_c) begin nc++; ic = i; end
    end
    check(bad_p == 0, exp_prev_valid && inf ? "R2" : "R8", "P slot output errors", bad_p, 0);
    check(bad_o == 0, "R2", "forwarded bit errors", bad_o, 0);
    check(bad_c == 0, cbit_mode ? "R6" : "R7", "CP slot output errors", bad_c, 0);
    check(np == (exp_pe ? 1 : 0) && (!exp_pe || ip == IP2),
          exp_prev_valid ? "R3" : "R8", "p_err count/index", np * 1000 + ip, exp_pe ? 1000 + IP2 : -1);
    check(nm == (exp_me ? 1 : 0) && (!exp_me || im == IP2),
          "R4", "p_mismatch count/index", nm * 1000 + im, exp_me ? 1000 + IP2 : -1);
    check(nc == (exp_ce ? 1 : 0) && (!exp_ce || ic == IC3),
          cbit_mode ? "R5" : "R7", "cp_err count/index", nc * 1000 + ic, exp_ce ? 1000 + IC3 : -1);
    if (gaps) check(bad_idle == 0, "R10", "idle cycle outputs", bad_idle, 0);
    exp_prev_par   = inf ? par : 1'b0;
    exp_prev_valid = inf;
    claim_flip     = (err == 4);
  endtask

  initial begin
    rst = 1'b1; bit_valid = 1'b0; frame_start = 1'b0; in_frame = 1'b1;
    rx_bit = 1'b1; cbit_mode = 1'b1; mid_net = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check({tx_bit, tx_valid, p_err, p_mismatch, cp_err} == 5'b0, "R9", "outputs in reset",
          int'({tx_bit, tx_valid, p_err, p_mismatch, cp_err}), 0);
    rst = 1'b0;
    // First frame after reset: wrong P-bits must not be flagged (R8)
    run_frame(1'b1, 3);
    for (int m = 0; m < 2; m++)
      for (int c = 0; c < 2; c++) begin
        mid_net = 1'(m); cbit_mode = 1'(c);
        for (int e = 0; e < 8; e++) run_frame(1'b1, e);
        run_frame(1'b1, 0);
      end
    // Idle gaps inside frames (R10, R1)
    gaps = 1'b1; mid_net = 1'b0; cbit_mode = 1'b1;
    for (int e = 0; e < 5; e++) run_frame(1'b1, e);
    run_frame(1'b1, 0);
    gaps = 1'b0;
    // Loss of lock, then recovery (R8)
    run_frame(1'b0, 3);
    run_frame(1'b1, 3);
    run_frame(1'b1, 3);
    run_frame(1'b1, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule